// File: doc/BRIEF.md
# Floppy Controller Interrupt Cause Reporter

This block sits between the step sequencer, the data-transfer engine and the host command port of a floppy disk controller. It gathers the events that should interrupt the host and drives one interrupt line. These events are: the end of a seek or recalibrate, a change on a drive's ready line, entry into a command's result phase, and non-DMA byte requests. Seek-type and ready-change events are held in one slot per drive. The host drains those slots with the sense-interrupt command. Each sense returns a cause byte and then the drive's present cylinder, and it frees the slot it served.

The block also screens every command the host issues. An undefined opcode is rejected, and so is any command other than sense-interrupt while a seek-type event is still unserved. A rejected command gets a single result byte of 80h and does not touch the interrupt line. A command that passes the screen is handed on through a one-cycle go pulse.

The state machine has four states. ST_IDLE accepts commands. ST_SENSE_ST0 presents the cause byte. ST_SENSE_PCN presents the cylinder byte. ST_INVALID presents 80h. The transitions are as follows:
- From ST_IDLE, a sense command with a slot pending goes to ST_SENSE_ST0.
- From ST_IDLE, a sense command with no slot pending goes to ST_INVALID.
- From ST_IDLE, a rejected command goes to ST_INVALID.
- From ST_IDLE, an accepted non-sense command stays in ST_IDLE and raises the go pulse.
- From ST_SENSE_ST0, a pop moves to ST_SENSE_PCN.
- From ST_SENSE_PCN, a pop returns to ST_IDLE.
- From ST_INVALID, a pop returns to ST_IDLE.

Top module: `fdc_irq_reporter`

## Requirements
- R1: A normal seek end on drive d sets irq on the next cycle. A later sense returns cause byte 20h|d and then the cylinder reported with that seek.
- R2: An abnormal seek end on drive d is reported as cause byte 70h|d. Bits 7:6 are 01, seek-end bit 5 is set, and equipment-check bit 4 is set. The cylinder reported with that seek follows.
- R3: A ready-line change on drive d is reported as cause byte C0h|d. It is followed by the last cylinder recorded for that drive, which is 0 after reset.
- R4: A sense command frees one slot, the lowest-numbered pending drive first. irq stays high while any slot remains pending and falls in the cycle after the last one is taken.
- R5: result_enter raises irq. The request is cleared by result_ack or by any sense command.
- R6: While ndma_req is high, irq is high in the same cycle.
- R7: The defined opcodes are 02h–0Dh except 0Bh, plus 0Fh, 11h, 19h and 1Dh; sense-interrupt is 08h. Any other opcode gives exactly one result byte 80h, no go pulse and no change on irq.
- R8: While a seek-type slot is pending, a command other than sense-interrupt is answered with 80h and no go pulse. The pending slot is kept.
- R9: A sense command with no slot pending returns the single byte 80h.
- R10: An accepted non-sense command raises cmd_go for exactly one cycle, starting the cycle after acceptance. cmd_ready and res_valid are never high together.
- R11: After reset, irq is low, cmd_ready is high, res_valid is low and every drive's cylinder is 0.
- R12: A new event for a drive whose slot is already pending replaces the older one. If a seek end and a ready change for the same drive arrive in the same cycle, the seek end is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seek_done | input | 1 | Seek or recalibrate finished |
| seek_drive | input | DRV_W | Drive of the finished seek |
| seek_fail | input | 1 | Seek ended abnormally |
| seek_cyl | input | CYL_W | Cylinder reached |
| ready_chg | input | 1 | Ready line changed |
| ready_drive | input | DRV_W | Drive whose ready line changed |
| result_enter | input | 1 | A command entered its result phase |
| result_ack | input | 1 | Host took that result |
| ndma_req | input | 1 | Non-DMA byte request |
| cmd_valid | input | 1 | Command opcode offered |
| cmd_opcode | input | 5 | Opcode |
| cmd_ready | output | 1 | Block is ready for a command |
| cmd_go | output | 1 | Pass command on (one cycle) |
| res_valid | output | 1 | Result byte presented |
| res_data | output | 8 | Result byte |
| res_pop | input | 1 | Host consumes result byte |
| irq | output | 1 | Interrupt line |

## Verification
A slot that fails to clear leaves irq high after the last sense result is popped, and it turns the next ordinary command into an 80h reply one cycle after issue. A wrong priority or a stale slot type shows in the first result byte, one cycle after the sense command is taken. A lost cylinder register shows in the second byte. A screening fault shows one cycle after acceptance, either as a spurious go pulse or as a missing 80h.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

    typedef enum logic [1:0] {
        EV_READY    = 2'd0,
        EV_SEEK_OK  = 2'd1,
        EV_SEEK_ERR = 2'd2
    } ev_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SENSE_ST0 = 2'd1,
        ST_SENSE_PCN = 2'd2,
        ST_INVALID   = 2'd3
    } rep_state_t;

    localparam logic [4:0] OPC_SENSE = 5'h08;
    localparam logic [7:0] BYTE_INVALID = 8'h80;

    // cause bits 7:4 for each event kind; drive number is OR-ed into 1:0
    function automatic logic [7:0] cause_code(input ev_kind_t k);
        logic [7:0] c;
        unique case (k)
            EV_READY:    c = 8'hC0;
            EV_SEEK_OK:  c = 8'h20;
            EV_SEEK_ERR: c = 8'h70;
            default:     c = 8'h80;
        endcase
        return c;
    endfunction

    function automatic logic opc_defined(input logic [4:0] op);
        logic d;
        case (op)
            5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08,
            5'h09, 5'h0A, 5'h0C, 5'h0D, 5'h0F,
            5'h11, 5'h19, 5'h1D: d = 1'b1;
            default:             d = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fdc_irq_slot_bank.sv
module fdc_irq_slot_bank
    import fdc_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              seek_done,
    input  logic [DRV_W-1:0]                  seek_drive,
    input  logic                              seek_fail,
    input  logic [CYL_W-1:0]                  seek_cyl,
    input  logic                              ready_chg,
    input  logic [DRV_W-1:0]                  ready_drive,
    input  logic                              clr_en,
    input  logic [DRV_W-1:0]                  clr_drive,
    output logic [NUM_DRIVES-1:0]             pend,
    output ev_kind_t [NUM_DRIVES-1:0]         kind,
    output logic [NUM_DRIVES-1:0][CYL_W-1:0]  cyl,
    output logic                              seek_pend
);

    logic [NUM_DRIVES-1:0] seek_slot;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_slot
        logic hit_seek, hit_rdy, hit_clr;

        always_comb begin
            hit_seek = seek_done && (seek_drive == DRV_W'(g));
            hit_rdy  = ready_chg && (ready_drive == DRV_W'(g));
            hit_clr  = clr_en    && (clr_drive  == DRV_W'(g));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
                kind[g] <= EV_READY;
                cyl[g]  <= '0;
            end else begin
                if (hit_seek) begin
                    pend[g] <= 1'b1;
                    kind[g] <= seek_fail ? EV_SEEK_ERR : EV_SEEK_OK;
                    cyl[g]  <= seek_cyl;
                end else if (hit_rdy) begin
                    pend[g] <= 1'b1;
                    kind[g] <= EV_READY;
                end else if (hit_clr) begin
                    pend[g] <= 1'b0;
                end
            end
        end

        assign seek_slot[g] = pend[g] && (kind[g] != EV_READY);
    end

    assign seek_pend = |seek_slot;

endmodule

// File: rtl/fdc_irq_pick.sv
module fdc_irq_pick #(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic [NUM_DRIVES-1:0] pend,
    output logic                  any,
    output logic [DRV_W-1:0]      idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = DRV_W'(i);
            end
        end
    end

endmodule

// File: rtl/fdc_cmd_screen.sv
module fdc_cmd_screen
    import fdc_irq_pkg::*;
(
    input  logic [4:0] opcode,
    input  logic       seek_pend,
    output logic       is_sense,
    output logic       reject
);

    always_comb begin
        is_sense = (opcode == OPC_SENSE);
        reject   = !opc_defined(opcode) || (seek_pend && !is_sense);
    end

endmodule

// File: rtl/fdc_irq_reporter.sv
module fdc_irq_reporter
    import fdc_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seek_done,
    input  logic [DRV_W-1:0] seek_drive,
    input  logic             seek_fail,
    input  logic [CYL_W-1:0] seek_cyl,
    input  logic             ready_chg,
    input  logic [DRV_W-1:0] ready_drive,
    input  logic             result_enter,
    input  logic             result_ack,
    input  logic             ndma_req,
    input  logic             cmd_valid,
    input  logic [4:0]       cmd_opcode,
    output logic             cmd_ready,
    output logic             cmd_go,
    output logic             res_valid,
    output logic [7:0]       res_data,
    input  logic             res_pop,
    output logic             irq
);

    rep_state_t state, state_nx;

    logic [NUM_DRIVES-1:0]             pend;
    ev_kind_t [NUM_DRIVES-1:0]         kind;
    logic [NUM_DRIVES-1:0][CYL_W-1:0]  cyl;
    logic                              seek_pend;
    logic                              any_pend;
    logic [DRV_W-1:0]                  pick_idx;
    logic                              is_sense, reject;
    logic                              take, sense_take, serve, go_nx;
    logic                              res_flag;
    logic [7:0]                        st0_q, pcn_q;
    logic                              go_q;

    fdc_irq_slot_bank #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .seek_done  (seek_done),
        .seek_drive (seek_drive),
        .seek_fail  (seek_fail),
        .seek_cyl   (seek_cyl),
        .ready_chg  (ready_chg),
        .ready_drive(ready_drive),
        .clr_en     (serve),
        .clr_drive  (pick_idx),
        .pend       (pend),
        .kind       (kind),
        .cyl        (cyl),
        .seek_pend  (seek_pend)
    );

    fdc_irq_pick #(.NUM_DRIVES(NUM_DRIVES)) u_pick (
        .pend(pend),
        .any (any_pend),
        .idx (pick_idx)
    );

    fdc_cmd_screen u_screen (
        .opcode   (cmd_opcode),
        .seek_pend(seek_pend),
        .is_sense (is_sense),
        .reject   (reject)
    );

    always_comb begin
        take       = cmd_valid && (state == ST_IDLE);
        sense_take = take && is_sense;
        serve      = sense_take && any_pend;
        go_nx      = take && !is_sense && !reject;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    if (serve)
                        state_nx = ST_SENSE_ST0;
                    else if (is_sense || reject)
                        state_nx = ST_INVALID;
                end
            end
            ST_SENSE_ST0: if (res_pop) state_nx = ST_SENSE_PCN;
            ST_SENSE_PCN: if (res_pop) state_nx = ST_IDLE;
            ST_INVALID:   if (res_pop) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register and captured result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            st0_q    <= '0;
            pcn_q    <= '0;
            go_q     <= 1'b0;
            res_flag <= 1'b0;
        end else begin
            state <= state_nx;
            go_q  <= go_nx;
            if (serve) begin
                st0_q <= cause_code(kind[pick_idx]) | (8'(pick_idx) & 8'h03);
                pcn_q <= 8'(cyl[pick_idx]);
            end
            if (result_enter)
                res_flag <= 1'b1;
            else if (result_ack || sense_take)
                res_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        res_valid = (state != ST_IDLE);
        cmd_go    = go_q;
        irq       = (|pend) || res_flag || ndma_req;
        unique case (state)
            ST_SENSE_ST0: res_data = st0_q;
            ST_SENSE_PCN: res_data = pcn_q;
            ST_INVALID:   res_data = BYTE_INVALID;
            default:      res_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/fdc_irq_reporter_chk.sv
module fdc_irq_reporter_chk
    import fdc_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [4:0] cmd_opcode,
    input logic       cmd_go,
    input logic       res_valid,
    input logic [7:0] res_data,
    input logic       seek_done,
    input logic       ready_chg,
    input logic       ndma_req,
    input logic       irq
);

    // R7
    undef_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !opc_defined(cmd_opcode))
            |=> (res_valid && res_data == 8'h80 && !cmd_go));

    // R1
    seek_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done |=> irq);

    // R3
    ready_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_chg |=> irq);

    // R6
    ndma_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ndma_req |-> irq);

    // R10
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && res_valid));

    // R10
    go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> ($past(cmd_valid && cmd_ready) && !res_valid));

endmodule

bind fdc_irq_reporter fdc_irq_reporter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_opcode(cmd_opcode),
    .cmd_go    (cmd_go),
    .res_valid (res_valid),
    .res_data  (res_data),
    .seek_done (seek_done),
    .ready_chg (ready_chg),
    .ndma_req  (ndma_req),
    .irq       (irq)
);

// File: tb/fdc_irq_reporter_test.sv
module fdc_irq_reporter_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] OP_SENSE = 5'h08;
    localparam logic [4:0] OP_READ  = 5'h06;
    localparam logic [4:0] OP_BAD   = 5'h1F;

    // vector: kind(2) drive(2) cyl(8) exp_st0(8) exp_cyl(8); kind 0=seek ok 1=seek fail 2=ready
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 2'd1, 8'h23, 8'h21, 8'h23},
        {2'd1, 2'd2, 8'h4C, 8'h72, 8'h4C},
        {2'd2, 2'd1, 8'h00, 8'hC1, 8'h23},
        {2'd0, 2'd0, 8'h00, 8'h20, 8'h00},
        {2'd2, 2'd3, 8'h00, 8'hC3, 8'h00},
        {2'd0, 2'd3, 8'h7F, 8'h23, 8'h7F},
        {2'd2, 2'd2, 8'h00, 8'hC2, 8'h4C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seek_done = 1'b0, seek_fail = 1'b0;
    logic [1:0] seek_drive = '0, ready_drive = '0;
    logic [7:0] seek_cyl = '0;
    logic       ready_chg = 1'b0, result_enter = 1'b0, result_ack = 1'b0;
    logic       ndma_req = 1'b0, cmd_valid = 1'b0, res_pop = 1'b0;
    logic [4:0] cmd_opcode = '0;
    logic       cmd_ready, cmd_go, res_valid, irq;
    logic [7:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_irq_reporter uut (
        .clk(clk), .rst_n(rst_n),
        .seek_done(seek_done), .seek_drive(seek_drive), .seek_fail(seek_fail),
        .seek_cyl(seek_cyl), .ready_chg(ready_chg), .ready_drive(ready_drive),
        .result_enter(result_enter), .result_ack(result_ack), .ndma_req(ndma_req),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_ready(cmd_ready),
        .cmd_go(cmd_go), .res_valid(res_valid), .res_data(res_data),
        .res_pop(res_pop), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic ev(input logic [1:0] k, input logic [1:0] d, input logic [7:0] c);
        @(negedge clk);
        if (k == 2'd2) begin
            ready_chg = 1'b1; ready_drive = d;
        end else begin
            seek_done = 1'b1; seek_drive = d; seek_fail = (k == 2'd1); seek_cyl = c;
        end
        @(negedge clk);
        ready_chg = 1'b0; seek_done = 1'b0; seek_fail = 1'b0;
    endtask

    task automatic cmd(input logic [4:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pop();
        res_pop = 1'b1;
        @(negedge clk);
        res_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 irq", 8'(irq), 8'h00);
        check("R11 cmd_ready", 8'(cmd_ready), 8'h01);
        check("R11 res_valid", 8'(res_valid), 8'h00);

        // table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            ev(VEC[i][27:26], VEC[i][25:24], VEC[i][23:16]);
            check("R1/R3 irq raised", 8'(irq), 8'h01);
            cmd(OP_SENSE);
            check("R1/R2/R3 st0", res_data, VEC[i][15:8]);
            check("R4 irq cleared", 8'(irq), 8'h00);
            pop();
            check("R1/R2/R3 cylinder", res_data, VEC[i][7:0]);
            pop();
            check("R10 back to idle", 8'(cmd_ready), 8'h01);
        end

        // R7 undefined opcode
        cmd(OP_BAD);
        check("R7 result", res_data, 8'h80);
        check("R7 res_valid", 8'(res_valid), 8'h01);
        check("R7 no irq", 8'(irq), 8'h00);
        check("R7 no go", 8'(cmd_go), 8'h00);
        pop();
        check("R7 single byte", 8'(res_valid), 8'h00);

        // R10 accepted command
        cmd(OP_READ);
        check("R10 go", 8'(cmd_go), 8'h01);
        check("R10 no result", 8'(res_valid), 8'h00);
        @(negedge clk);
        check("R10 go one cycle", 8'(cmd_go), 8'h00);

        // R9 sense with empty queue
        cmd(OP_SENSE);
        check("R9 result", res_data, 8'h80);
        pop();
        check("R9 single byte", 8'(res_valid), 8'h00);

        // R8 non-sense while seek pending
        ev(2'd0, 2'd0, 8'h05);
        cmd(OP_READ);
        check("R8 result", res_data, 8'h80);
        check("R8 no go", 8'(cmd_go), 8'h00);
        pop();
        check("R8 irq kept", 8'(irq), 8'h01);
        cmd(OP_SENSE);
        check("R8 slot kept", res_data, 8'h20);
        pop();
        check("R8 cylinder", res_data, 8'h05);
        pop();
        check("R8 irq cleared", 8'(irq), 8'h00);

        // R4 priority and irq held while slots remain
        @(negedge clk);
        ready_chg = 1'b1; ready_drive = 2'd2;
        seek_done = 1'b1; seek_drive = 2'd1; seek_cyl = 8'h11;
        @(negedge clk);
        ready_chg = 1'b0; seek_done = 1'b0;
        cmd(OP_SENSE);
        check("R4 lowest drive first", res_data, 8'h21);
        check("R4 irq held", 8'(irq), 8'h01);
        pop(); pop();
        cmd(OP_SENSE);
        check("R4 second slot", res_data, 8'hC2);
        check("R4 irq drops", 8'(irq), 8'h00);
        pop(); pop();

        // R12 replacement, and seek wins on same-cycle collision
        ev(2'd0, 2'd0, 8'h09);
        ev(2'd2, 2'd0, 8'h00);
        cmd(OP_SENSE);
        check("R12 replaced", res_data, 8'hC0);
        pop();
        check("R12 cylinder", res_data, 8'h09);
        pop();
        check("R12 one slot only", 8'(irq), 8'h00);
        @(negedge clk);
        ready_chg = 1'b1; ready_drive = 2'd3;
        seek_done = 1'b1; seek_drive = 2'd3; seek_fail = 1'b1; seek_cyl = 8'h0A;
        @(negedge clk);
        ready_chg = 1'b0; seek_done = 1'b0; seek_fail = 1'b0;
        cmd(OP_SENSE);
        check("R12 seek wins", res_data, 8'h73);
        pop(); pop();

        // R5 result-phase interrupt
        @(negedge clk);
        result_enter = 1'b1;
        @(negedge clk);
        result_enter = 1'b0;
        check("R5 irq set", 8'(irq), 8'h01);
        result_ack = 1'b1;
        @(negedge clk);
        result_ack = 1'b0;
        check("R5 ack clears", 8'(irq), 8'h00);
        result_enter = 1'b1;
        @(negedge clk);
        result_enter = 1'b0;
        cmd(OP_SENSE);
        check("R5 sense clears", 8'(irq), 8'h00);
        check("R9 empty queue", res_data, 8'h80);
        pop();

        // R6 non-DMA request
        @(negedge clk);
        ndma_req = 1'b1;
        #1;
        check("R6 irq follows", 8'(irq), 8'h01);
        @(negedge clk);
        ndma_req = 1'b0;
        #1;
        check("R6 irq releases", 8'(irq), 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule